// File: doc/BRIEF.md
# Interrupt Controller Host Register Front End

This block is the processor-facing front end of a synchronous interrupt controller. It samples an active-low chip select, active-low read, write and interrupt-acknowledge strobes, one address bit and an 8-bit data bus. It runs the start-up configuration sequence, keeps the run-time command state, and answers reads with status bytes. It also passes eight asynchronous request lines through a two-flop synchronizer for the priority logic that follows it.

Every bus input is synchronous to `clk`. An input is accepted only on a rising edge where the active-low qualifier `clk_en_n` is 0. The qualifier acts as a register enable and is never used as a clock. Each assertion of a strobe acts exactly once, however long it is held. The request and in-service vectors belong to the downstream core. This block only selects between them on reads.

Top module: `pic_hif_top`

## Requirements
- R1: After synchronous reset, `init_done`, `mask`, `rd_vld`, `special_mask`, `rd_isr_sel` and all configuration outputs are 0.
- R2: A bus or acknowledge strobe has an effect only on a rising edge where `clk_en_n` is 0. A strobe held low across a disabled edge and released has no effect. If it is still low when the qualifier falls, it is accepted at that edge.
- R3: Each low assertion of a read, write or acknowledge strobe acts once, however many enabled edges it spans. Read and write strobes are ignored while `cs_n` is 1.
- R4: A write with `a0`=0 and data bit 4 = 1 starts configuration from any state. It clears `init_done`, `mask`, `special_mask`, `rd_isr_sel`, the vector base, the cascade byte and the mode bits. It latches bit 0 as `need_mode`, bit 1 as `single` and bit 3 as `level_trig`.
- R5: After the start word, writes with `a0`=1 are taken in order: vector base (data bits 7:3), then the cascade byte (skipped when `single`=1), then the mode word (bits 4:0, skipped when `need_mode`=0). `init_done` rises after the last word taken.
- R6: Once `init_done` is 1, a write with `a0`=1 loads `mask`. Before that, such a write does not reach `mask`.
- R7: With `init_done` at 1, a write with `a0`=0 and data bits 4:3 = 00 raises `eoi_vld` for exactly one cycle, with the written byte on `eoi_data`.
- R8: With `init_done` at 1, a write with `a0`=0 and data bits 4:3 = 01 is a run-time select word. If bit 1 = 1, `rd_isr_sel` takes bit 0. If bit 6 = 1, `special_mask` takes bit 5. If bit 2 = 1, `poll_req` pulses for one cycle.
- R9: A read accepted at a rising edge raises `rd_vld` for the following cycle. `rd_data` holds the response until the next accepted read. The response is `mask` when `a0`=1. When `a0`=0 it is `isr_in` if `rd_isr_sel`=1 and `irr_in` otherwise.
- R10: Each accepted low assertion of `inta_n` raises `ack_pulse` for one cycle, independent of `cs_n`.
- R11: `req_sync` equals `req_async` delayed by exactly two rising edges of `clk`, regardless of `clk_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low sampling qualifier |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| inta_n | input | 1 | Interrupt-acknowledge strobe, active low |
| a0 | input | 1 | Register address bit |
| din | input | 8 | Write data |
| irr_in | input | 8 | Request register contents from the core |
| isr_in | input | 8 | In-service register contents from the core |
| req_async | input | 8 | Asynchronous request lines |
| rd_data | output | 8 | Read response |
| rd_vld | output | 1 | Read response valid, one cycle |
| req_sync | output | 8 | Synchronized request lines |
| init_done | output | 1 | Configuration sequence complete |
| need_mode | output | 1 | Mode word expected |
| single | output | 1 | No cascade byte expected |
| level_trig | output | 1 | Level-triggered request mode |
| vec_base | output | 5 | Vector base bits |
| casc_cfg | output | 8 | Cascade configuration byte |
| mode_cfg | output | 5 | Mode word bits |
| mask | output | 8 | Mask register |
| eoi_vld | output | 1 | End-of-service command strobe |
| eoi_data | output | 8 | End-of-service command byte |
| rd_isr_sel | output | 1 | Address-0 read selects in-service vector |
| special_mask | output | 1 | Special mask mode |
| poll_req | output | 1 | Poll command strobe |
| ack_pulse | output | 1 | Accepted acknowledge strobe |

## Verification
A corrupt configuration state shows up at the next write that follows the start word. An extra or missing step leaves `init_done` low, or lets `mask` change one word early, and either is visible on the cycle after that write. A broken enable or edge qualifier shows up as an extra `eoi_vld` or `ack_pulse` while a strobe is held, or as a mask change across a disabled edge; the next read with `a0`=1 exposes it. A wrong read select appears as a wrong byte on `rd_data` one cycle after the read strobe is accepted. A short synchronizer shows up as `req_sync` changing one edge early.

// File: rtl/pic_hif_pkg.sv
package pic_hif_pkg;

    localparam int DATA_W      = 8;
    localparam int REQ_W       = 8;
    localparam int SYNC_STAGES = 2;

    // Bit positions decoded from written bytes
    localparam int B_START     = 4;
    localparam int B_SELW      = 3;
    localparam int B_NEEDMODE  = 0;
    localparam int B_SINGLE    = 1;
    localparam int B_LEVEL     = 3;
    localparam int B_RDSEL_EN  = 1;
    localparam int B_RDSEL_VAL = 0;
    localparam int B_POLL      = 2;
    localparam int B_SMM_EN    = 6;
    localparam int B_SMM_VAL   = 5;

    typedef enum logic [2:0] {
        ST_UNINIT = 3'd0,
        ST_VEC    = 3'd1,
        ST_CASC   = 3'd2,
        ST_MODE   = 3'd3,
        ST_READY  = 3'd4
    } cfg_state_e;

    typedef struct packed {
        logic        need_mode;
        logic        single;
        logic        level_trig;
        logic [4:0]  vec_base;
        logic [7:0]  casc;
        logic [4:0]  mode;
    } init_cfg_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              ack;
        logic              a0;
        logic [DATA_W-1:0] data;
    } host_req_t;

    function automatic logic is_start_word(input logic a0, input logic [DATA_W-1:0] d);
        return (!a0) && d[B_START];
    endfunction

    function automatic cfg_state_e after_vec(input logic single, input logic need_mode);
        if (!single)
            return ST_CASC;
        else if (need_mode)
            return ST_MODE;
        else
            return ST_READY;
    endfunction

    function automatic cfg_state_e after_casc(input logic need_mode);
        return need_mode ? ST_MODE : ST_READY;
    endfunction

endpackage

// File: rtl/pic_hif_sync.sv
module pic_hif_sync
    import pic_hif_pkg::*;
#(
    parameter int WIDTH  = REQ_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

    p_two_edge_delay_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)))
        else $error("synchronizer latency wrong");

endmodule

// File: rtl/pic_hif_strobe.sv
module pic_hif_strobe #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] acc
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_strobe
            logic idle_q;
            always_ff @(posedge clk) begin
                if (rst)
                    idle_q <= 1'b1;
                else if (!en_n)
                    idle_q <= strobe_n[i];
            end
            assign acc[i] = !en_n && !strobe_n[i] && idle_q;

            p_once_per_assert_r3: assert property (@(posedge clk) disable iff (rst)
                acc[i] |=> !acc[i])
                else $error("strobe accepted twice in a row");
        end
    endgenerate

endmodule

// File: rtl/pic_hif_cmd.sv
module pic_hif_cmd
    import pic_hif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              wr_acc,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    output init_cfg_t         cfg,
    output logic              init_done,
    output logic [DATA_W-1:0] mask,
    output logic              eoi_vld,
    output logic [DATA_W-1:0] eoi_data,
    output logic              rd_isr_sel,
    output logic              special_mask,
    output logic              poll_req
);
    cfg_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_UNINIT;
            cfg          <= '0;
            mask         <= '0;
            eoi_vld      <= 1'b0;
            eoi_data     <= '0;
            rd_isr_sel   <= 1'b0;
            special_mask <= 1'b0;
            poll_req     <= 1'b0;
        end else begin
            eoi_vld  <= 1'b0;
            poll_req <= 1'b0;
            if (wr_acc) begin
                if (is_start_word(a0, din)) begin
                    cfg.need_mode  <= din[B_NEEDMODE];
                    cfg.single     <= din[B_SINGLE];
                    cfg.level_trig <= din[B_LEVEL];
                    cfg.vec_base   <= '0;
                    cfg.casc       <= '0;
                    cfg.mode       <= '0;
                    mask           <= '0;
                    rd_isr_sel     <= 1'b0;
                    special_mask   <= 1'b0;
                    state          <= ST_VEC;
                end else begin
                    unique case (state)
                        ST_VEC: if (a0) begin
                            cfg.vec_base <= din[7:3];
                            state        <= after_vec(cfg.single, cfg.need_mode);
                        end
                        ST_CASC: if (a0) begin
                            cfg.casc <= din;
                            state    <= after_casc(cfg.need_mode);
                        end
                        ST_MODE: if (a0) begin
                            cfg.mode <= din[4:0];
                            state    <= ST_READY;
                        end
                        ST_READY: begin
                            if (a0) begin
                                mask <= din;
                            end else if (din[B_SELW]) begin
                                if (din[B_RDSEL_EN])
                                    rd_isr_sel <= din[B_RDSEL_VAL];
                                if (din[B_SMM_EN])
                                    special_mask <= din[B_SMM_VAL];
                                poll_req <= din[B_POLL];
                            end else begin
                                eoi_vld  <= 1'b1;
                                eoi_data <= din;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign init_done = (state == ST_READY);

    p_mask_needs_enable_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(en_n)) |-> $stable(mask))
        else $error("mask changed on a disabled edge");

    p_done_after_addr1_write_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> ($past(wr_acc) && $past(a0)))
        else $error("configuration completed without a word");

    p_mask_frozen_uninit_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(init_done) && !$past(wr_acc && !a0)) |-> $stable(mask))
        else $error("mask written before configuration finished");

    p_eoi_single_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        eoi_vld |=> !eoi_vld)
        else $error("end-of-service strobe longer than one cycle");

    p_poll_single_cycle_r8: assert property (@(posedge clk) disable iff (rst)
        poll_req |=> !poll_req)
        else $error("poll strobe longer than one cycle");

endmodule

// File: rtl/pic_hif_top.sv
module pic_hif_top
    import pic_hif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              inta_n,
    input  logic              a0,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] irr_in,
    input  logic [DATA_W-1:0] isr_in,
    input  logic [REQ_W-1:0]  req_async,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic [REQ_W-1:0]  req_sync,
    output logic              init_done,
    output logic              need_mode,
    output logic              single,
    output logic              level_trig,
    output logic [4:0]        vec_base,
    output logic [7:0]        casc_cfg,
    output logic [4:0]        mode_cfg,
    output logic [DATA_W-1:0] mask,
    output logic              eoi_vld,
    output logic [DATA_W-1:0] eoi_data,
    output logic              rd_isr_sel,
    output logic              special_mask,
    output logic              poll_req,
    output logic              ack_pulse
);
    localparam int N_STB = 3;
    localparam int I_WR  = 0;
    localparam int I_RD  = 1;
    localparam int I_ACK = 2;

    logic [N_STB-1:0] stb_n;
    logic [N_STB-1:0] stb_acc;
    host_req_t        req;
    init_cfg_t        cfg;

    assign stb_n[I_WR]  = wr_n | cs_n;
    assign stb_n[I_RD]  = rd_n | cs_n;
    assign stb_n[I_ACK] = inta_n;

    pic_hif_strobe #(.N(N_STB)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .en_n     (clk_en_n),
        .strobe_n (stb_n),
        .acc      (stb_acc)
    );

    assign req.wr   = stb_acc[I_WR];
    assign req.rd   = stb_acc[I_RD];
    assign req.ack  = stb_acc[I_ACK];
    assign req.a0   = a0;
    assign req.data = din;

    pic_hif_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_async),
        .q   (req_sync)
    );

    pic_hif_cmd u_cmd (
        .clk          (clk),
        .rst          (rst),
        .en_n         (clk_en_n),
        .wr_acc       (req.wr),
        .a0           (req.a0),
        .din          (req.data),
        .cfg          (cfg),
        .init_done    (init_done),
        .mask         (mask),
        .eoi_vld      (eoi_vld),
        .eoi_data     (eoi_data),
        .rd_isr_sel   (rd_isr_sel),
        .special_mask (special_mask),
        .poll_req     (poll_req)
    );

    assign need_mode  = cfg.need_mode;
    assign single     = cfg.single;
    assign level_trig = cfg.level_trig;
    assign vec_base   = cfg.vec_base;
    assign casc_cfg   = cfg.casc;
    assign mode_cfg   = cfg.mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_vld    <= 1'b0;
            ack_pulse <= 1'b0;
        end else begin
            rd_vld    <= req.rd;
            ack_pulse <= req.ack;
            if (req.rd)
                rd_data <= req.a0 ? mask : (rd_isr_sel ? isr_in : irr_in);
        end
    end

    p_rd_vld_follows_read_r9: assert property (@(posedge clk) disable iff (rst)
        rd_vld |-> $past(req.rd))
        else $error("read response without a read");

    p_rd_data_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(req.rd)) |-> $stable(rd_data))
        else $error("read data changed without a read");

    p_ack_single_r10: assert property (@(posedge clk) disable iff (rst)
        ack_pulse |=> !ack_pulse)
        else $error("acknowledge pulse too long");

endmodule

// File: tb/pic_hif_top_tb_top.sv
`timescale 1ns/1ps
module pic_hif_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, inta_n = 1'b1, a0 = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] irr_in = 8'h3C, isr_in = 8'h81, req_async = '0;
    logic [7:0] rd_data, req_sync, casc_cfg, mask, eoi_data;
    logic [4:0] vec_base, mode_cfg;
    logic       rd_vld, init_done, need_mode, single, level_trig;
    logic       eoi_vld, rd_isr_sel, special_mask, poll_req, ack_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic       cap_eoi, cap_poll;
    logic [7:0] cap_eoi_data;

    always #10 clk = ~clk;

    pic_hif_top dut_i (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .inta_n(inta_n), .a0(a0), .din(din), .irr_in(irr_in),
        .isr_in(isr_in), .req_async(req_async), .rd_data(rd_data), .rd_vld(rd_vld),
        .req_sync(req_sync), .init_done(init_done), .need_mode(need_mode),
        .single(single), .level_trig(level_trig), .vec_base(vec_base),
        .casc_cfg(casc_cfg), .mode_cfg(mode_cfg), .mask(mask), .eoi_vld(eoi_vld),
        .eoi_data(eoi_data), .rd_isr_sel(rd_isr_sel), .special_mask(special_mask),
        .poll_req(poll_req), .ack_pulse(ack_pulse)
    );

    // {op(2: 0 write, 1 read-check), a0, data, expected}
    localparam int NV = 13;
    localparam logic [18:0] VEC [NV] = '{
        {2'd0, 1'b0, 8'h1B, 8'h00},
        {2'd0, 1'b1, 8'h40, 8'h00},
        {2'd0, 1'b1, 8'h1D, 8'h00},
        {2'd1, 1'b1, 8'h00, 8'h00},
        {2'd0, 1'b1, 8'hA5, 8'h00},
        {2'd1, 1'b1, 8'h00, 8'hA5},
        {2'd1, 1'b0, 8'h00, 8'h3C},
        {2'd0, 1'b0, 8'h0B, 8'h00},
        {2'd1, 1'b0, 8'h00, 8'h81},
        {2'd0, 1'b0, 8'h0A, 8'h00},
        {2'd1, 1'b0, 8'h00, 8'h3C},
        {2'd0, 1'b0, 8'h09, 8'h00},
        {2'd1, 1'b0, 8'h00, 8'h3C}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic addr, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = addr; din = d;
        @(negedge clk);
        cap_eoi = eoi_vld; cap_eoi_data = eoi_data; cap_poll = poll_req;
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic addr, input logic [7:0] exp, input string req);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = addr;
        @(negedge clk);
        chk(rd_vld === 1'b1, req, rd_vld, 1);
        chk(rd_data === exp, req, rd_data, exp);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        chk(rd_vld === 1'b0, req, rd_vld, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(init_done === 1'b0 && mask === 8'h00 && rd_vld === 1'b0, "R1", {init_done, mask}, 0);
        chk({special_mask, rd_isr_sel, vec_base, casc_cfg, mode_cfg} === '0, "R1", vec_base, 0);
        rst = 1'b0;
        @(negedge clk);

        // R6: mask write before configuration is dropped
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, 8'h00, "R6 pre-init mask");

        // Table walk: R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18:17] == 2'd0)
                bus_write(VEC[i][16], VEC[i][15:8]);
            else
                bus_read(VEC[i][16], VEC[i][7:0], "R9 table read");
        end

        // R4/R5 configuration fields (single, mode word taken, no cascade byte)
        chk(init_done === 1'b1, "R5 done", init_done, 1);
        chk(vec_base === 5'h08, "R5 vec_base", vec_base, 5'h08);
        chk(single === 1'b1 && level_trig === 1'b1 && need_mode === 1'b1, "R4 flags",
            {need_mode, single, level_trig}, 3'b111);
        chk(mode_cfg === 5'h1D && casc_cfg === 8'h00, "R5 mode/casc", {mode_cfg, casc_cfg}, {5'h1D, 8'h00});

        // R3: write without chip select ignored
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; a0 = 1'b1; din = 8'h11;
        @(negedge clk);
        wr_n = 1'b1;
        bus_read(1'b1, 8'hA5, "R3 cs_n high");

        // R2: strobe through a disabled edge only, then released
        @(negedge clk);
        clk_en_n = 1'b1; cs_n = 1'b0; wr_n = 1'b0; a0 = 1'b1; din = 8'h33;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        clk_en_n = 1'b0;
        bus_read(1'b1, 8'hA5, "R2 disabled edge");

        // R2: strobe held across disable, then qualifier falls -> accepted
        @(negedge clk);
        clk_en_n = 1'b1; cs_n = 1'b0; wr_n = 1'b0; a0 = 1'b1; din = 8'h77;
        @(negedge clk);
        clk_en_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        bus_read(1'b1, 8'h77, "R2 late enable");

        // R3/R7: held write strobe gives one end-of-service strobe
        cnt = 0;
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = 1'b0; din = 8'h63;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (eoi_vld) begin
                cnt++;
                chk(eoi_data === 8'h63, "R7 data", eoi_data, 8'h63);
            end
        end
        cs_n = 1'b1; wr_n = 1'b1;
        chk(cnt == 1, "R3 held strobe", cnt, 1);

        bus_write(1'b0, 8'h20);
        chk(cap_eoi === 1'b1 && cap_eoi_data === 8'h20, "R7 pulse", cap_eoi_data, 8'h20);
        chk(eoi_vld === 1'b0, "R7 one cycle", eoi_vld, 0);

        // R8: poll, special mask
        bus_write(1'b0, 8'h0C);
        chk(cap_poll === 1'b1 && cap_eoi === 1'b0, "R8 poll", cap_poll, 1);
        bus_write(1'b0, 8'h68);
        chk(special_mask === 1'b1, "R8 smm set", special_mask, 1);
        bus_write(1'b0, 8'h28);
        chk(special_mask === 1'b1, "R8 smm kept", special_mask, 1);
        bus_write(1'b0, 8'h48);
        chk(special_mask === 1'b0, "R8 smm clear", special_mask, 0);

        // R10: held acknowledge acts once, without chip select
        cnt = 0;
        @(negedge clk);
        inta_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (ack_pulse) cnt++;
        end
        inta_n = 1'b1;
        @(negedge clk);
        chk(cnt == 1 && ack_pulse === 1'b0, "R10 ack", cnt, 1);

        // R11: two-edge synchronizer, with qualifier disabled
        @(negedge clk);
        clk_en_n = 1'b1; req_async = 8'h5A;
        @(negedge clk);
        chk(req_sync === 8'h00, "R11 first edge", req_sync, 8'h00);
        @(negedge clk);
        chk(req_sync === 8'h5A, "R11 second edge", req_sync, 8'h5A);
        clk_en_n = 1'b0;

        // R4/R5: reconfigure with cascade byte and no mode word
        bus_write(1'b0, 8'h0B);
        chk(rd_isr_sel === 1'b1, "R8 isr select", rd_isr_sel, 1);
        bus_write(1'b0, 8'h10);
        chk(init_done === 1'b0 && rd_isr_sel === 1'b0 && mode_cfg === 5'h0, "R4 restart",
            {init_done, rd_isr_sel}, 0);
        bus_read(1'b1, 8'h00, "R4 mask cleared");
        bus_write(1'b1, 8'h20);
        chk(init_done === 1'b0 && vec_base === 5'h04, "R5 wait cascade", {init_done, vec_base}, 5'h04);
        bus_write(1'b1, 8'h04);
        chk(init_done === 1'b1 && casc_cfg === 8'h04 && need_mode === 1'b0, "R5 cascade done",
            {init_done, casc_cfg}, {1'b1, 8'h04});
        bus_read(1'b0, 8'h3C, "R9 select reset to request");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule